// File: doc/BRIEF.md
# Block Address Translator

This block translates a 32-bit effective address through a small set of block-mapping entries, with no table walk. It holds two banks of register pairs, one for instruction fetches and one for loads and stores. Each pair has an upper word, which describes the effective block and when the pair is valid, and a lower word, which gives the real block and its protection code. Software loads the pairs through a synchronous write port. Translation itself is purely combinational. Each cycle the block takes an effective address, an access kind and a privilege bit, and it returns a hit flag, the real address, the granted rights and a permission-fault flag.

The block length is a mask, and it does two jobs. It widens the match window, and it lets the masked effective-address bits pass into the real address. The pairs are searched from index 0 upward. The first pair that matches and is valid for the current privilege decides the result, even when its rights do not cover the access. The surrounding memory unit uses a miss to fall back to segment and page translation. It uses a fault to raise a protection exception.

Top module: `bat_xlate_top`

## Requirements
- R1: The access kind is encoded 0 = load, 1 = store, 2 = instruction fetch and 3 = load. Kind 2 searches only the instruction bank. Kinds 0, 1 and 3 search only the data bank.
- R2: A write with `cfg_we` high updates one word on the rising clock edge. `cfg_iside` = 1 selects the instruction bank, `cfg_idx` selects the pair and `cfg_hi` = 1 selects the upper word. A synchronous active-low reset clears every word, so every access then misses.
- R3: The upper word holds the effective block high part in bits 31:28, the effective block low part in bits 27:17 and the block length in bits 12:2. A pair matches when EA[31:28] equals the high part and EA[27:17], with the block-length bits cleared, equals the low part.
- R4: Upper-word bit 1 makes a pair valid for supervisor accesses (`acc_user` = 0). Upper-word bit 0 makes it valid for user accesses (`acc_user` = 1). A matching pair that is not valid for the current privilege is skipped.
- R5: The lower word holds a protection code in bits 1:0. `xl_rights` is {execute, write, read}. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R6: The lower word holds the real block high part in bits 31:28 and the low part in bits 27:17. The real address is the OR of these parts, EA[27:17] under the block-length mask, and EA[16:12]. Bits 11:0 of the real address are zero.
- R7: Among matching valid pairs, the lowest index decides the hit, address and rights, even when its rights deny the access.
- R8: On a hit, `xl_fault` is 1 when the access is not covered by the rights. A fetch needs execute, a store needs write and a load needs read.
- R9: When no valid pair matches, `xl_hit`, `xl_fault`, `xl_rights` and `xl_ra` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Synchronous active-low reset; clears all words |
| cfg_we | input | 1 | Register write enable |
| cfg_iside | input | 1 | 1 = instruction bank, 0 = data bank |
| cfg_idx | input | 2 | Pair index to write |
| cfg_hi | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wdata | input | 32 | Word to write |
| acc_ea | input | 32 | Effective address of the access |
| acc_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| acc_user | input | 1 | 1 = user state, 0 = supervisor state |
| xl_hit | output | 1 | A valid pair matched |
| xl_ra | output | 32 | Translated real address |
| xl_rights | output | 3 | Granted rights {execute, write, read} |
| xl_fault | output | 1 | Access not permitted by the deciding pair |

## Verification
Translation is combinational, so a wrong stored word shows up on `xl_ra` or `xl_hit` in the same cycle as the first access that selects that pair. A write into the wrong bank or index shows up in one of two ways. Either the wrong side hits, or a lower-priority pair answers in place of the intended one. An error in priority or validity selection appears as a real address taken from the wrong block. It can also appear as a fault that should have been a success, or the other way round. The vectors are built so that overlapping pairs give different real addresses, which makes each of these errors visible.

// File: rtl/bat_xlate_pkg.sv
// Package: shared sizes, field positions and types for the block address
// translator. Assumes a 32-bit address and 128 KiB minimum block granule.
package bat_xlate_pkg;
    parameter int ADDR_W   = 32;
    parameter int NUM_PAIR = 4;
    parameter int HI_W     = 4;              // high block field width
    parameter int LO_W     = 11;             // low block / length field width
    parameter int PG_W     = 5;              // pass-through page bits
    localparam int IDX_W   = $clog2(NUM_PAIR);
    localparam int HI_LSB  = ADDR_W - HI_W;  // 28
    localparam int LO_LSB  = HI_LSB - LO_W;  // 17
    localparam int PG_LSB  = LO_LSB - PG_W;  // 12
    localparam int BL_LSB  = 2;              // block length at 12:2
    localparam int VS_BIT  = 1;              // supervisor valid
    localparam int VU_BIT  = 0;              // user valid

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic exec;
        logic write;
        logic read;
    } rights_t;

    typedef struct packed {
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] lower;
    } pair_t;
endpackage

// File: rtl/bat_pair_store.sv
// Module: register store for both banks of translation pairs.
// Assumes one word written per cycle; reset is synchronous, active low.
module bat_pair_store
    import bat_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 iside,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 hi,
    input  logic [ADDR_W-1:0]    wdata,
    input  logic                 fetch_sel,
    output pair_t                sel_pairs [NUM_PAIR]
);
    pair_t ibank [NUM_PAIR];
    pair_t dbank [NUM_PAIR];

    for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
        // Write or clear one instruction-bank pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ibank[g] <= '0;
            end else if (we && iside && idx == IDX_W'(g)) begin
                if (hi) ibank[g].upper <= wdata;
                else    ibank[g].lower <= wdata;
            end
        end

        // Write or clear one data-bank pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dbank[g] <= '0;
            end else if (we && !iside && idx == IDX_W'(g)) begin
                if (hi) dbank[g].upper <= wdata;
                else    dbank[g].lower <= wdata;
            end
        end

        // Present the bank matching the access side.
        always_comb begin
            sel_pairs[g] = fetch_sel ? ibank[g] : dbank[g];
        end
    end
endmodule

// File: rtl/bat_entry_eval.sv
// Module: evaluates one pair against an effective address: match, privilege
// validity, protection decode and real-address merge. Purely combinational.
module bat_entry_eval
    import bat_xlate_pkg::*;
(
    input  pair_t              pair,
    input  logic [ADDR_W-1:0]  ea,
    input  logic               user,
    output logic               hit,
    output logic [ADDR_W-1:0]  ra,
    output rights_t            rights
);
    logic [LO_W-1:0] len_mask;
    logic            hi_eq;
    logic            lo_eq;
    logic            valid;
    logic [1:0]      prot;

    // Extract the block-length mask and compare the block fields.
    always_comb begin
        len_mask = pair.upper[BL_LSB +: LO_W];
        hi_eq    = ea[HI_LSB +: HI_W] == pair.upper[HI_LSB +: HI_W];
        lo_eq    = (ea[LO_LSB +: LO_W] & ~len_mask) == pair.upper[LO_LSB +: LO_W];
        valid    = user ? pair.upper[VU_BIT] : pair.upper[VS_BIT];
        hit      = hi_eq && lo_eq && valid;
    end

    // Decode the protection code into rights.
    always_comb begin
        prot   = pair.lower[1:0];
        rights = '0;
        if (prot != 2'd0) begin
            rights.read  = 1'b1;
            rights.exec  = 1'b1;
            rights.write = (prot == 2'd2);
        end
    end

    // Merge real block fields with masked and pass-through address bits.
    always_comb begin
        ra = '0;
        ra[HI_LSB +: HI_W] = pair.lower[HI_LSB +: HI_W];
        ra[LO_LSB +: LO_W] = pair.lower[LO_LSB +: LO_W] | (ea[LO_LSB +: LO_W] & len_mask);
        ra[PG_LSB +: PG_W] = ea[PG_LSB +: PG_W];
    end
endmodule

// File: rtl/bat_first_pick.sv
// Module: priority selector; the lowest-index hitting entry supplies the
// result. Assumes per-entry address and rights are meaningful only on hit.
module bat_first_pick
    import bat_xlate_pkg::*;
(
    input  logic               hits   [NUM_PAIR],
    input  logic [ADDR_W-1:0]  ras    [NUM_PAIR],
    input  rights_t            rts    [NUM_PAIR],
    output logic               any_hit,
    output logic [ADDR_W-1:0]  pick_ra,
    output rights_t            pick_rt
);
    // Walk from the top index down so the lowest hitting index is kept.
    always_comb begin
        any_hit = 1'b0;
        pick_ra = '0;
        pick_rt = '0;
        for (int i = NUM_PAIR - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                pick_ra = ras[i];
                pick_rt = rts[i];
            end
        end
    end
endmodule

// File: rtl/bat_xlate_top.sv
// Module: block address translator top. Stores the pairs, evaluates the
// bank chosen by access kind, picks the first valid match and checks the
// requested access against its rights. Outputs are combinational.
module bat_xlate_top
    import bat_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_iside,
    input  logic [1:0]  cfg_idx,
    input  logic        cfg_hi,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] acc_ea,
    input  logic [1:0]  acc_kind,
    input  logic        acc_user,
    output logic        xl_hit,
    output logic [31:0] xl_ra,
    output logic [2:0]  xl_rights,
    output logic        xl_fault
);
    logic              is_fetch;
    pair_t             pairs  [NUM_PAIR];
    logic              e_hit  [NUM_PAIR];
    logic [ADDR_W-1:0] e_ra   [NUM_PAIR];
    rights_t           e_rt   [NUM_PAIR];
    logic              f_hit;
    logic [ADDR_W-1:0] f_ra;
    rights_t           f_rt;
    logic              allowed;

    // Fetches use the instruction bank; all other kinds use the data bank.
    always_comb is_fetch = (acc_kind_e'(acc_kind) == ACC_FETCH);

    bat_pair_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .iside     (cfg_iside),
        .idx       (cfg_idx),
        .hi        (cfg_hi),
        .wdata     (cfg_wdata),
        .fetch_sel (is_fetch),
        .sel_pairs (pairs)
    );

    for (genvar g = 0; g < NUM_PAIR; g++) begin : g_eval
        bat_entry_eval u_eval (
            .pair   (pairs[g]),
            .ea     (acc_ea),
            .user   (acc_user),
            .hit    (e_hit[g]),
            .ra     (e_ra[g]),
            .rights (e_rt[g])
        );
    end

    bat_first_pick u_pick (
        .hits    (e_hit),
        .ras     (e_ra),
        .rts     (e_rt),
        .any_hit (f_hit),
        .pick_ra (f_ra),
        .pick_rt (f_rt)
    );

    // Check the requested access against the chosen rights.
    always_comb begin
        case (acc_kind_e'(acc_kind))
            ACC_FETCH: allowed = f_rt.exec;
            ACC_STORE: allowed = f_rt.write;
            default:   allowed = f_rt.read;
        endcase
    end

    // Drive the result ports.
    always_comb begin
        xl_hit    = f_hit;
        xl_ra     = f_ra;
        xl_rights = f_rt;
        xl_fault  = f_hit && !allowed;
    end
endmodule

// File: rtl/bat_xlate_chk.sv
// Checker: port-level properties of the block address translator.
module bat_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] acc_ea,
    input logic [1:0]  acc_kind,
    input logic        xl_hit,
    input logic [31:0] xl_ra,
    input logic [2:0]  xl_rights,
    input logic        xl_fault
);
    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_ra == 32'd0 && xl_rights == 3'd0 && !xl_fault));

    // R5
    rights_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_rights == 3'b000 || xl_rights == 3'b101 || xl_rights == 3'b111));

    // R6
    page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_ra[16:12] == acc_ea[16:12] && xl_ra[11:0] == 12'd0));

    // R8
    store_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && acc_kind == 2'd1) |-> (xl_fault == !xl_rights[1]));

    // R8
    fetch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && acc_kind == 2'd2) |-> (xl_fault == !xl_rights[2]));

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !xl_hit);
endmodule

bind bat_xlate_top bat_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ea    (acc_ea),
    .acc_kind  (acc_kind),
    .xl_hit    (xl_hit),
    .xl_ra     (xl_ra),
    .xl_rights (xl_rights),
    .xl_fault  (xl_fault)
);

// File: tb/test_bat_xlate_top.sv
module test_bat_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_iside = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic        cfg_hi = 1'b0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] acc_ea = 32'd0;
    logic [1:0]  acc_kind = 2'd0;
    logic        acc_user = 1'b0;
    logic        xl_hit;
    logic [31:0] xl_ra;
    logic [2:0]  xl_rights;
    logic        xl_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bat_xlate_top i_bat_xlate_top (.*);

    // Vector: ea, kind, user, hit, ra, rights, fault
    localparam int NV = 13;
    localparam logic [71:0] VEC [NV] = '{
        {32'h1000_3456, 2'd0, 1'b0, 1'b1, 32'h8002_3000, 3'b111, 1'b0},
        {32'h1000_3456, 2'd1, 1'b0, 1'b1, 32'h8002_3000, 3'b111, 1'b0},
        {32'h1000_3456, 2'd0, 1'b1, 1'b1, 32'hA200_3000, 3'b111, 1'b0},
        {32'h1016_5000, 2'd1, 1'b1, 1'b1, 32'hA216_5000, 3'b111, 1'b0},
        {32'h1016_5000, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0},
        {32'h2ABC_DEF0, 2'd0, 1'b1, 1'b1, 32'h3ABC_D000, 3'b101, 1'b0},
        {32'h2ABC_DEF0, 2'd1, 1'b1, 1'b1, 32'h3ABC_D000, 3'b101, 1'b1},
        {32'h2ABC_DEF0, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0},
        {32'h1000_7000, 2'd2, 1'b1, 1'b1, 32'h5004_7000, 3'b101, 1'b0},
        {32'h1000_7000, 2'd1, 1'b1, 1'b1, 32'hA200_7000, 3'b111, 1'b0},
        {32'h4020_0000, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 3'b000, 1'b1},
        {32'h1000_3456, 2'd3, 1'b0, 1'b1, 32'h8002_3000, 3'b111, 1'b0},
        {32'h4020_0000, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0}
    };
    string tags [NV] = '{"R3 R6", "R8", "R4", "R3 R6", "R9", "R5 R6", "R8",
                         "R1", "R1", "R1", "R5 R8", "R1", "R1"};

    function automatic logic [31:0] up_w(logic [3:0] h, logic [10:0] l,
                                         logic [10:0] bl, logic vs, logic vu);
        return {h, l, 4'd0, bl, vs, vu};
    endfunction

    function automatic logic [31:0] lo_w(logic [3:0] h, logic [10:0] l, logic [1:0] pp);
        return {h, l, 15'd0, pp};
    endfunction

    task automatic wr(input logic side, input logic [1:0] idx, input logic hi,
                      input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_iside = side; cfg_idx = idx; cfg_hi = hi; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [31:0] ea, input logic [1:0] k,
                         input logic u, input logic eh, input logic [31:0] era,
                         input logic [2:0] ert, input logic ef);
        @(negedge clk);
        acc_ea = ea; acc_kind = k; acc_user = u;
        #1;
        n_chk++;
        if (xl_hit !== eh || xl_ra !== era || xl_rights !== ert || xl_fault !== ef) begin
            n_fail++;
            $display("FAIL %s ea=%h: got hit=%b ra=%h rt=%b flt=%b, want hit=%b ra=%h rt=%b flt=%b",
                     tag, ea, xl_hit, xl_ra, xl_rights, xl_fault, eh, era, ert, ef);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R2: cleared after reset, every access misses
        probe("R2", 32'h0000_0000, 2'd0, 1'b0, 1'b0, 32'd0, 3'b000, 1'b0);
        probe("R2", 32'h0000_0000, 2'd2, 1'b1, 1'b0, 32'd0, 3'b000, 1'b0);

        // Data bank
        wr(1'b0, 2'd0, 1'b1, up_w(4'h1, 11'h000, 11'h000, 1'b1, 1'b0));
        wr(1'b0, 2'd0, 1'b0, lo_w(4'h8, 11'h001, 2'd2));
        wr(1'b0, 2'd1, 1'b1, up_w(4'h2, 11'h000, 11'h7FF, 1'b1, 1'b1));
        wr(1'b0, 2'd1, 1'b0, lo_w(4'h3, 11'h000, 2'd1));
        wr(1'b0, 2'd2, 1'b1, up_w(4'h1, 11'h000, 11'h00F, 1'b0, 1'b1));
        wr(1'b0, 2'd2, 1'b0, lo_w(4'hA, 11'h100, 2'd2));
        wr(1'b0, 2'd3, 1'b1, up_w(4'h4, 11'h010, 11'h000, 1'b1, 1'b1));
        wr(1'b0, 2'd3, 1'b0, lo_w(4'h0, 11'h000, 2'd0));
        // Instruction bank
        wr(1'b1, 2'd0, 1'b1, up_w(4'h1, 11'h000, 11'h000, 1'b1, 1'b1));
        wr(1'b1, 2'd0, 1'b0, lo_w(4'h5, 11'h002, 2'd1));

        for (int i = 0; i < NV; i++) begin
            probe(tags[i], VEC[i][71:40], VEC[i][39:38], VEC[i][37], VEC[i][36],
                  VEC[i][35:4], VEC[i][3:1], VEC[i][0]);
        end

        // R7: pair 2 now supervisor-valid too; pair 0 still wins
        wr(1'b0, 2'd2, 1'b1, up_w(4'h1, 11'h000, 11'h00F, 1'b1, 1'b1));
        probe("R7", 32'h1000_3456, 2'd0, 1'b0, 1'b1, 32'h8002_3000, 3'b111, 1'b0);
        // R4: pair 2 supervisor-valid now answers where pair 0 does not match
        probe("R4", 32'h1016_5000, 2'd0, 1'b0, 1'b1, 32'hA216_5000, 3'b111, 1'b0);
        // R7: pair 0 read-only; store faults, no fall-through to pair 2
        wr(1'b0, 2'd0, 1'b0, lo_w(4'h8, 11'h001, 2'd1));
        probe("R7", 32'h1000_3456, 2'd1, 1'b0, 1'b1, 32'h8002_3000, 3'b101, 1'b1);
        // R5: protection code 3 gives read and execute
        wr(1'b0, 2'd0, 1'b0, lo_w(4'h8, 11'h001, 2'd3));
        probe("R5", 32'h1000_3456, 2'd0, 1'b0, 1'b1, 32'h8002_3000, 3'b101, 1'b0);

        // R2: reset mid-run clears both banks
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        probe("R2", 32'h1000_3456, 2'd0, 1'b0, 1'b0, 32'd0, 3'b000, 1'b0);
        probe("R2", 32'h1000_7000, 2'd2, 1'b1, 1'b0, 32'd0, 3'b000, 1'b0);

        finish_run();
    end
endmodule